// File: doc/BRIEF.md
# Two-Level Per-Link Interrupt Aggregator

This block collects interrupt events for a device with a parameterized number of links (sixteen by default) and reduces them to one active-low interrupt pin. Every link owns a status register and an enable register of six category bits. Link 0's pair is wider, because device-wide sources are folded into it alone. Examples of such sources are receive FIFO overflow and counter events. Each source arrives as a one-cycle event pulse. Its status bit latches the event and holds it until software clears it. The bit latches whether or not the source is enabled.

The second level is a master status register with one read-only bit per link. Bit n is set while any bit of link n is both pending and enabled. A master enable register decides which links may drive the pin. The pin is registered, so it cannot glitch.

Software reaches everything through a simple register port. Reads return data one clock after they are requested. The address map is fixed:
- Link n status is at `n` (0x00 to 0x0F).
- Link n enable is at `0x10 + n`.
- Master status is at `0x20`.
- Master enable is at `0x21`.

Every other address reads as zero and ignores writes.

Top module: `irq_aggr_top`

## Requirements
- R1: After reset, all status, enable and master enable registers read 0, `reg_rdata_o` is 0 and `irq_n_o` is 1.
- R2: A pulse on `evt_link_i[n*6+b]` sets bit b of link n's status (address n) on the sampling edge, whether or not that bit is enabled.
- R3: Writing to a link status address clears each bit where the write data holds 1 and leaves bits written 0 unchanged; status bits never clear otherwise.
- R4: If an event pulse and a clearing write hit the same status bit in one cycle, the bit stays set.
- R5: `evt_glb_i[g]` sets bit 6+g of link 0's status. Bits 6 and up of every other link's status and enable read 0, and writes to them have no effect.
- R6: Master status bit n (address 0x20) is 1 exactly when link n has a bit that is set in both its status and its enable register. Writes to 0x20 have no effect.
- R7: `irq_n_o` is 0 in the cycle after master status AND master enable (address 0x21) is nonzero, and 1 in the cycle after it is zero.
- R8: Enabling a source whose status bit is already pending sets the link's master status bit at the edge that writes the enable.
- R9: `reg_rdata_o` updates only on an edge where `reg_rd_i` is 1. It returns the addressed register as it was before that edge, and returns 0 for unmapped addresses.
- R10: Enable registers read back the written value, limited to the link's implemented width (10 bits for link 0, 6 bits for the others, 16 for master enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_link_i | input | 96 | Per-link category event pulses, bit n*6+b is link n category b |
| evt_glb_i | input | 4 | Device-wide event pulses, routed into link 0 bits 6..9 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid the cycle after the read strobe |
| irq_n_o | output | 1 | Registered active-low interrupt pin |

## Verification
An event or clearing write sampled at edge k changes status at edge k, so the result shows in a read issued at edge k+1. The pin moves at edge k+1, one register after the combinational master status. The bench drives every stimulus half a cycle away from the edge and samples 1 ns after each edge. On both sides of the pin's transition it checks that the pin still holds its old value after edge k and has taken the new value after edge k+1. Read data is captured right after the edge that samples the read strobe.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

  // Address region held in the two top address bits.
  typedef enum logic [1:0] {
    RGN_STAT = 2'b00,
    RGN_EN   = 2'b01,
    RGN_MST  = 2'b10,
    RGN_RSVD = 2'b11
  } rgn_e;

  localparam int unsigned CAT_W_DEF  = 6;
  localparam int unsigned GLB_W_DEF  = 4;
  localparam int unsigned LINKS_DEF  = 16;
  localparam int unsigned DATA_W_DEF = 16;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_nxt;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irq_link_reg.sv
module irq_link_reg #(
  parameter int unsigned SRC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] evt_i,
  input  logic             clr_we_i,
  input  logic             en_we_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] stat_o,
  output logic [SRC_W-1:0] en_o,
  output logic             any_o
);

  logic [SRC_W-1:0] stat_q, stat_nxt;
  logic [SRC_W-1:0] en_q, en_nxt;
  logic [SRC_W-1:0] clr_mask;
  logic             stat_ce, en_ce;

  always_comb begin
    clr_mask = clr_we_i ? wdata_i : '0;
    // New events dominate a same-cycle clear.
    stat_nxt = (stat_q & ~clr_mask) | evt_i;
    stat_ce  = clr_we_i | (|evt_i);
    en_nxt   = wdata_i;
    en_ce    = en_we_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_ce) begin
      stat_q <= stat_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_nxt;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign any_o  = |(stat_q & en_q);

endmodule

// File: rtl/irq_master.sv
module irq_master #(
  parameter int unsigned NUM_LINKS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINKS-1:0] link_any_i,
  input  logic                 mst_en_we_i,
  input  logic [NUM_LINKS-1:0] wdata_i,
  output logic [NUM_LINKS-1:0] mst_stat_o,
  output logic [NUM_LINKS-1:0] mst_en_o,
  output logic                 irq_n_o
);

  logic [NUM_LINKS-1:0] mst_en_q, mst_en_nxt;
  logic                 irq_n_q, irq_n_nxt;

  always_comb begin
    mst_en_nxt = wdata_i;
    irq_n_nxt  = ~(|(link_any_i & mst_en_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst_en_q <= '0;
    end else if (mst_en_we_i) begin
      mst_en_q <= mst_en_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n_q <= 1'b1;
    end else begin
      irq_n_q <= irq_n_nxt;
    end
  end

  assign mst_stat_o = link_any_i;
  assign mst_en_o   = mst_en_q;
  assign irq_n_o    = irq_n_q;

endmodule

// File: rtl/irq_regif.sv
module irq_regif
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_LINKS = 16,
  parameter int unsigned LINK_W    = 10,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned ADDR_W    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr_i,
  input  logic                        reg_rd_i,
  input  logic [ADDR_W-1:0]           reg_addr_i,
  input  logic [NUM_LINKS*LINK_W-1:0] stat_flat_i,
  input  logic [NUM_LINKS*LINK_W-1:0] en_flat_i,
  input  logic [NUM_LINKS-1:0]        mst_stat_i,
  input  logic [NUM_LINKS-1:0]        mst_en_i,
  output logic [NUM_LINKS-1:0]        clr_we_o,
  output logic [NUM_LINKS-1:0]        en_we_o,
  output logic                        mst_en_we_o,
  output logic [DATA_W-1:0]           rdata_o
);

  rgn_e             rgn;
  logic [IDX_W-1:0] idx;
  logic             idx_ok;
  logic             mst_sel_stat, mst_sel_en;
  logic [DATA_W-1:0] rdata_q, rdata_nxt;

  always_comb begin
    rgn          = rgn_e'(reg_addr_i[ADDR_W-1 -: 2]);
    idx          = reg_addr_i[IDX_W-1:0];
    idx_ok       = {1'b0, idx} < (IDX_W+1)'(NUM_LINKS);
    mst_sel_stat = (rgn == RGN_MST) && (idx == '0);
    mst_sel_en   = (rgn == RGN_MST) && (idx == IDX_W'(1));
  end

  // Write strobes, one per link register.
  always_comb begin
    for (int n = 0; n < NUM_LINKS; n++) begin
      clr_we_o[n] = reg_wr_i && (rgn == RGN_STAT) && (idx == IDX_W'(n));
      en_we_o[n]  = reg_wr_i && (rgn == RGN_EN)   && (idx == IDX_W'(n));
    end
    mst_en_we_o = reg_wr_i && mst_sel_en;
  end

  // Read multiplexer.
  always_comb begin
    rdata_nxt = '0;
    unique case (rgn)
      RGN_STAT: if (idx_ok) rdata_nxt[LINK_W-1:0] = stat_flat_i[idx*LINK_W +: LINK_W];
      RGN_EN:   if (idx_ok) rdata_nxt[LINK_W-1:0] = en_flat_i[idx*LINK_W +: LINK_W];
      RGN_MST: begin
        if (mst_sel_stat) rdata_nxt[NUM_LINKS-1:0] = mst_stat_i;
        if (mst_sel_en)   rdata_nxt[NUM_LINKS-1:0] = mst_en_i;
      end
      default: rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (reg_rd_i) begin
      rdata_q <= rdata_nxt;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NUM_LINKS = LINKS_DEF,
  parameter int unsigned CAT_W     = CAT_W_DEF,
  parameter int unsigned GLB_W     = GLB_W_DEF,
  parameter int unsigned DATA_W    = DATA_W_DEF,
  localparam int unsigned LINK_W   = CAT_W + GLB_W,
  localparam int unsigned IDX_W    = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1,
  localparam int unsigned ADDR_W   = IDX_W + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LINKS*CAT_W-1:0] evt_link_i,
  input  logic [GLB_W-1:0]          evt_glb_i,
  input  logic                      reg_wr_i,
  input  logic                      reg_rd_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]         reg_wdata_i,
  output logic [DATA_W-1:0]         reg_rdata_o,
  output logic                      irq_n_o
);

  logic                        rst_sync_n;
  logic [NUM_LINKS*LINK_W-1:0] stat_flat;
  logic [NUM_LINKS*LINK_W-1:0] en_flat;
  logic [NUM_LINKS-1:0]        link_any;
  logic [NUM_LINKS-1:0]        clr_we, en_we;
  logic                        mst_en_we;
  logic [NUM_LINKS-1:0]        mst_stat, mst_en;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar n = 0; n < NUM_LINKS; n++) begin : g_link
    if (n == 0) begin : g_wide
      logic [LINK_W-1:0] st, en;
      irq_link_reg #(.SRC_W(LINK_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .evt_i    ({evt_glb_i, evt_link_i[CAT_W-1:0]}),
        .clr_we_i (clr_we[n]),
        .en_we_i  (en_we[n]),
        .wdata_i  (reg_wdata_i[LINK_W-1:0]),
        .stat_o   (st),
        .en_o     (en),
        .any_o    (link_any[n])
      );
      assign stat_flat[n*LINK_W +: LINK_W] = st;
      assign en_flat[n*LINK_W +: LINK_W]   = en;
    end else begin : g_narrow
      logic [CAT_W-1:0] st, en;
      irq_link_reg #(.SRC_W(CAT_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .evt_i    (evt_link_i[n*CAT_W +: CAT_W]),
        .clr_we_i (clr_we[n]),
        .en_we_i  (en_we[n]),
        .wdata_i  (reg_wdata_i[CAT_W-1:0]),
        .stat_o   (st),
        .en_o     (en),
        .any_o    (link_any[n])
      );
      assign stat_flat[n*LINK_W +: LINK_W] = {{GLB_W{1'b0}}, st};
      assign en_flat[n*LINK_W +: LINK_W]   = {{GLB_W{1'b0}}, en};
    end
  end

  irq_master #(.NUM_LINKS(NUM_LINKS)) u_mst (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .link_any_i  (link_any),
    .mst_en_we_i (mst_en_we),
    .wdata_i     (reg_wdata_i[NUM_LINKS-1:0]),
    .mst_stat_o  (mst_stat),
    .mst_en_o    (mst_en),
    .irq_n_o     (irq_n_o)
  );

  irq_regif #(
    .NUM_LINKS (NUM_LINKS),
    .LINK_W    (LINK_W),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .ADDR_W    (ADDR_W)
  ) u_regif (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .stat_flat_i (stat_flat),
    .en_flat_i   (en_flat),
    .mst_stat_i  (mst_stat),
    .mst_en_i    (mst_en),
    .clr_we_o    (clr_we),
    .en_we_o     (en_we),
    .mst_en_we_o (mst_en_we),
    .rdata_o     (reg_rdata_o)
  );

endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk #(
  parameter int unsigned NUM_LINKS = 16,
  parameter int unsigned CAT_W     = 6,
  parameter int unsigned GLB_W     = 4,
  parameter int unsigned LINK_W    = 10,
  parameter int unsigned ADDR_W    = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_LINKS*CAT_W-1:0]  evt_link_i,
  input logic [GLB_W-1:0]            evt_glb_i,
  input logic                        reg_wr_i,
  input logic [ADDR_W-1:0]           reg_addr_i,
  input logic [NUM_LINKS*LINK_W-1:0] stat_flat,
  input logic [NUM_LINKS*LINK_W-1:0] en_flat,
  input logic [NUM_LINKS-1:0]        mst_stat,
  input logic [NUM_LINKS-1:0]        mst_en,
  input logic                        irq_n_o
);

  logic stat_wr;
  assign stat_wr = reg_wr_i && (reg_addr_i[ADDR_W-1 -: 2] == 2'b00);

  for (genvar n = 0; n < NUM_LINKS; n++) begin : g_link_chk
    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_link_i[n*CAT_W +: CAT_W]) |=>
        ((stat_flat[n*LINK_W +: CAT_W] & $past(evt_link_i[n*CAT_W +: CAT_W]))
          == $past(evt_link_i[n*CAT_W +: CAT_W]))); // R4
  end

  AST_GLB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_glb_i) |=>
      ((stat_flat[CAT_W +: GLB_W] & $past(evt_glb_i)) == $past(evt_glb_i))); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((stat_flat & $past(stat_flat)) == $past(stat_flat))); // R3

  AST_MST_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    (|mst_stat) == (|(stat_flat & en_flat))); // R6

  AST_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mst_stat & mst_en)) |=> !irq_n_o); // R7

  AST_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(mst_stat & mst_en)) |=> irq_n_o); // R7

endmodule

bind irq_aggr_top irq_aggr_chk #(
  .NUM_LINKS (NUM_LINKS),
  .CAT_W     (CAT_W),
  .GLB_W     (GLB_W),
  .LINK_W    (LINK_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .evt_link_i (evt_link_i),
  .evt_glb_i  (evt_glb_i),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .stat_flat  (stat_flat),
  .en_flat    (en_flat),
  .mst_stat   (mst_stat),
  .mst_en     (mst_en),
  .irq_n_o    (irq_n_o)
);

// File: tb/tb_irq_aggr_top.sv
`timescale 1ns/1ps
module tb_irq_aggr_top;

  logic        clk;
  logic        rst_n;
  logic [95:0] evt_link;
  logic [3:0]  evt_glb;
  logic        reg_wr, reg_rd;
  logic [5:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  irq_aggr_top dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_link_i  (evt_link),
    .evt_glb_i   (evt_glb),
    .reg_wr_i    (reg_wr),
    .reg_rd_i    (reg_rd),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_n_o     (irq_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int link, input int bitn);
    @(negedge clk);
    evt_link[link*6 + bitn] = 1'b1;
    @(posedge clk); #1;
    evt_link = '0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 pin", {15'd0, irq_n}, 16'h1);
    check("R1 rdata", reg_rdata, 16'h0);
    do_rd(6'h00, d); check("R1 link0 status", d, 16'h0);
    do_rd(6'h10, d); check("R1 link0 enable", d, 16'h0);
    do_rd(6'h21, d); check("R1 master enable", d, 16'h0);
    do_rd(6'h20, d); check("R1 master status", d, 16'h0);
  endtask

  task automatic t_latch_masked();
    logic [15:0] d;
    pulse(3, 2);
    do_rd(6'h03, d); check("R2 masked latch", d, 16'h0004);
    do_rd(6'h20, d); check("R6 masked no master", d, 16'h0);
    check("R7 pin idle", {15'd0, irq_n}, 16'h1);
  endtask

  task automatic t_enable_exposes();
    logic [15:0] d;
    do_wr(6'h13, 16'h0004);
    do_rd(6'h13, d); check("R10 link3 enable", d, 16'h0004);
    do_rd(6'h20, d); check("R8 exposed", d, 16'h0008);
    do_wr(6'h21, 16'h0008);
    check("R7 pin before", {15'd0, irq_n}, 16'h1);
    @(posedge clk); #1;
    check("R7 pin asserted", {15'd0, irq_n}, 16'h0);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    do_wr(6'h03, 16'h0000);
    do_rd(6'h03, d); check("R3 write zero keeps", d, 16'h0004);
    check("R7 still low", {15'd0, irq_n}, 16'h0);
    do_wr(6'h03, 16'h0004);
    check("R7 pin lags clear", {15'd0, irq_n}, 16'h0);
    @(posedge clk); #1;
    check("R7 pin released", {15'd0, irq_n}, 16'h1);
    do_rd(6'h03, d); check("R3 cleared", d, 16'h0);
    do_rd(6'h20, d); check("R6 master clears", d, 16'h0);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    pulse(5, 1);
    @(negedge clk);
    evt_link[5*6 + 0] = 1'b1;
    reg_wr = 1'b1; reg_addr = 6'h05; reg_wdata = 16'h0003;
    @(posedge clk); #1;
    evt_link = '0; reg_wr = 1'b0;
    do_rd(6'h05, d); check("R4 set wins", d, 16'h0001);
    do_wr(6'h05, 16'h0001);
    do_rd(6'h05, d); check("R3 final clear", d, 16'h0);
  endtask

  task automatic t_global();
    logic [15:0] d;
    @(negedge clk); evt_glb = 4'b0010;
    @(posedge clk); #1; evt_glb = '0;
    pulse(0, 0);
    do_rd(6'h00, d); check("R5 global in link0", d, 16'h0081);
    do_rd(6'h01, d); check("R5 link1 untouched", d, 16'h0);
    do_wr(6'h17, 16'hFFC0);
    do_rd(6'h17, d); check("R5 upper enable ignored", d, 16'h0);
    do_wr(6'h10, 16'hFFFF);
    do_rd(6'h10, d); check("R10 link0 enable width", d, 16'h03FF);
    do_rd(6'h20, d); check("R6 link0 master", d, 16'h0001);
    do_wr(6'h00, 16'h0080);
    do_rd(6'h00, d); check("R3 clear global only", d, 16'h0001);
  endtask

  task automatic t_master_ro();
    logic [15:0] d;
    do_wr(6'h20, 16'hFFFF);
    do_rd(6'h20, d); check("R6 master read-only", d, 16'h0001);
    do_rd(6'h30, d); check("R9 unmapped zero", d, 16'h0);
    do_rd(6'h10, d);
    @(negedge clk); reg_addr = 6'h21;
    @(posedge clk); #1;
    check("R9 hold without read", reg_rdata, 16'h03FF);
  endtask

  task automatic t_multi();
    logic [15:0] d;
    pulse(9, 5);
    do_wr(6'h19, 16'h0020);
    do_rd(6'h20, d); check("R6 two links", d, 16'h0201);
    do_wr(6'h21, 16'hFFFF);
    do_rd(6'h21, d); check("R10 master enable", d, 16'hFFFF);
    check("R7 pin multi", {15'd0, irq_n}, 16'h0);
    do_wr(6'h21, 16'h0004);
    @(posedge clk); #1;
    check("R7 master masks", {15'd0, irq_n}, 16'h1);
    do_wr(6'h21, 16'h0200);
    @(posedge clk); #1;
    check("R7 link9 drives", {15'd0, irq_n}, 16'h0);
  endtask

  initial begin
    rst_n = 1'b0; evt_link = '0; evt_glb = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_latch_masked();
    t_enable_exposes();
    t_w1c();
    t_set_wins();
    t_global();
    t_master_ro();
    t_multi();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule